// File: doc/BRIEF.md
# PWM Fault Auto-Shutdown Controller

This block sits between a PWM generator and the four output pads of a bridge driver. It watches up to three trip sources (two comparator trip lines and an active-low fault pin), selected in any combination by a mask. When an enabled source trips, it takes all four pins to a programmed safe state at once, with no clock edge in the path. Each pin pair has its own safe state: drive low, drive high or released.

A trip also sets a latched shutdown flag. The flag is cleared in one of two ways. With auto-restart enabled, the hardware clears it once every enabled source has gone quiet. Otherwise software must clear it through a one-bit write port, and that port is locked out while a trip is still present. After the flag clears, normal PWM drive does not return straight away. It comes back only at a period-start strobe, so a partial pulse never reaches the bridge. Generating the waveform itself belongs to the block upstream.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset the flag is clear, auto-restart is off, no source is selected, and every pin follows its `pwm_in` bit with its output-enable at 1.
- R2: The trip condition is the OR of the enabled sources. The `src_sel` bits enable sources as follows: bit0 enables `cmp1_trip` (high trips), bit1 enables `cmp2_trip` (high trips), bit2 enables `fault_n` (low trips). With `src_sel` = 000 the pins always follow the PWM.
- R3: While an enabled source trips, the pins show their safe state in the same cycle, before any clock edge.
- R4: Pins 0 and 2 use `safe_ac` and pins 1 and 3 use `safe_bd`. The codes are 00 = drive 0 with enable 1, 01 = drive 1 with enable 1, and 1x = enable 0 with level 0.
- R5: With `auto_restart` = 1, the flag clears on the first edge at which no enabled source trips. Normal drive returns after the next `period_start` edge that follows.
- R6: With `auto_restart` = 0, the flag stays set after the trip goes away. Period strobes do not restore the pins until software writes 0 while no trip is present.
- R7: A software write to the flag made while a trip is present has no effect.
- R8: Normal drive returns only on a `period_start` edge at which the flag is already clear. If the flag is set at that edge, the pins stay safe for the whole period that follows.
- R9: A software write of 1 with no trip present sets the flag, and the pins go safe from the next edge.
- R10: A trip that is present at a `period_start` edge takes priority, and the pins remain safe after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp1_trip | input | 1 | Comparator 1 trip, high = trip |
| cmp2_trip | input | 1 | Comparator 2 trip, high = trip |
| fault_n | input | 1 | Fault pin, low = trip |
| src_sel | input | 3 | Trip source enable mask |
| safe_ac | input | 2 | Safe-state code for pins 0 and 2 |
| safe_bd | input | 2 | Safe-state code for pins 1 and 3 |
| auto_restart | input | 1 | 1 = hardware clears the flag when trips end |
| sw_wr | input | 1 | Software write strobe for the flag |
| sw_wdata | input | 1 | Value written to the flag |
| period_start | input | 1 | One-cycle strobe at each PWM period start |
| pwm_in | input | 4 | Normal PWM levels for the four pins |
| pin_out | output | 4 | Pin levels |
| pin_oe | output | 4 | Pin output-enables |

## Verification
Two events can land on the same clock edge: the automatic clearing of the flag and a period-start strobe. The bench provokes this by dropping the trip and raising `period_start` in the same cycle. It expects the pins to stay safe after that edge and to recover only at the next strobe. A trip held across a strobe edge is judged the same way, and the pins must stay safe after that edge as well.

// File: rtl/trip_pkg.sv
package trip_pkg;
    localparam int N_SRC  = 3;
    localparam int N_PINS = 4;
    localparam int CODE_W = 2;

    typedef struct packed {
        logic lvl;
        logic oe;
    } drive_t;

    // code[1] set releases the pin; otherwise code[0] is the driven level
    function automatic drive_t safe_drive(input logic [CODE_W-1:0] code);
        drive_t d;
        if (code[1]) begin
            d.lvl = 1'b0;
            d.oe  = 1'b0;
        end else begin
            d.lvl = code[0];
            d.oe  = 1'b1;
        end
        return d;
    endfunction

    function automatic logic in_pair_ac(input int idx);
        return (idx % 2) == 0;
    endfunction
endpackage

// File: rtl/trip_detect.sv
module trip_detect #(
    parameter int N_SRC = trip_pkg::N_SRC
) (
    input  logic [N_SRC-1:0] raw_trip,
    input  logic [N_SRC-1:0] src_sel,
    output logic             fault
);
    assign fault = |(raw_trip & src_sel);
endmodule

// File: rtl/trip_latch.sv
module trip_latch (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic auto_restart,
    input  logic sw_wr,
    input  logic sw_wdata,
    input  logic period_start,
    output logic flag_q,
    output logic run_q
);
    always_ff @(posedge clk) begin
        if (rst)               flag_q <= 1'b0;
        else if (fault)        flag_q <= 1'b1;
        else if (auto_restart) flag_q <= 1'b0;
        else if (sw_wr)        flag_q <= sw_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                   run_q <= 1'b1;
        else if (fault || flag_q)  run_q <= 1'b0;
        else if (period_start)     run_q <= 1'b1;
    end

    // R7: a write while tripped leaves the flag set
    p_write_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (fault && sw_wr) |=> flag_q);

    // R5: automatic clearing one edge after the trip ends
    p_auto_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (auto_restart && !fault && flag_q) |=> !flag_q);

    // R8: run only resumes on a period strobe
    p_resume_on_period_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> $past(period_start));

    // R10: a trip always stops the run state
    p_trip_stops_run_r10: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!run_q && flag_q));
endmodule

// File: rtl/pin_safe_mux.sv
module pin_safe_mux #(
    parameter int N_PINS = trip_pkg::N_PINS,
    parameter int CODE_W = trip_pkg::CODE_W
) (
    input  logic              shut,
    input  logic [CODE_W-1:0] safe_ac,
    input  logic [CODE_W-1:0] safe_bd,
    input  logic [N_PINS-1:0] pwm_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);
    import trip_pkg::*;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic [CODE_W-1:0] code;
        drive_t            sd;
        assign code = in_pair_ac(i) ? safe_ac : safe_bd;
        assign sd   = safe_drive(code);
        assign pin_out[i] = shut ? sd.lvl : pwm_in[i];
        assign pin_oe[i]  = shut ? sd.oe  : 1'b1;
    end
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmp1_trip,
    input  logic       cmp2_trip,
    input  logic       fault_n,
    input  logic [2:0] src_sel,
    input  logic [1:0] safe_ac,
    input  logic [1:0] safe_bd,
    input  logic       auto_restart,
    input  logic       sw_wr,
    input  logic       sw_wdata,
    input  logic       period_start,
    input  logic [3:0] pwm_in,
    output logic [3:0] pin_out,
    output logic [3:0] pin_oe
);
    import trip_pkg::*;

    logic [N_SRC-1:0] raw_trip;
    logic             fault;
    logic             flag_q;
    logic             run_q;
    logic             shut;

    assign raw_trip = {~fault_n, cmp2_trip, cmp1_trip};

    trip_detect #(.N_SRC(N_SRC)) u_detect (
        .raw_trip (raw_trip),
        .src_sel  (src_sel),
        .fault    (fault)
    );

    trip_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .fault        (fault),
        .auto_restart (auto_restart),
        .sw_wr        (sw_wr),
        .sw_wdata     (sw_wdata),
        .period_start (period_start),
        .flag_q       (flag_q),
        .run_q        (run_q)
    );

    // combinational trip path keeps the safe state edge-free
    assign shut = fault | flag_q | ~run_q;

    pin_safe_mux #(.N_PINS(N_PINS), .CODE_W(CODE_W)) u_mux (
        .shut    (shut),
        .safe_ac (safe_ac),
        .safe_bd (safe_bd),
        .pwm_in  (pwm_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // R1: state right after reset
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!flag_q && run_q));

    // R3: a trip with both pairs set to drive-high shows at the pins at once
    p_trip_immediate_r3: assert property (@(posedge clk) disable iff (rst)
        (fault && safe_ac == 2'b01 && safe_bd == 2'b01) |-> (pin_out == 4'hF && pin_oe == 4'hF));

    // R4: a release code on pair A/C removes drive from pins 0 and 2
    p_release_ac_r4: assert property (@(posedge clk) disable iff (rst)
        (fault && safe_ac[1]) |-> (!pin_oe[0] && !pin_oe[2]));

    // R2: with no source selected the pins keep following the PWM while running
    p_no_source_r2: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 3'b000 && !flag_q && run_q) |-> (pin_out == pwm_in && pin_oe == 4'hF));
endmodule

// File: tb/sim_pwm_trip_guard.sv
module sim_pwm_trip_guard;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp1_trip = 1'b0, cmp2_trip = 1'b0, fault_n = 1'b1;
    logic [2:0] src_sel = 3'b000;
    logic [1:0] safe_ac = 2'b00, safe_bd = 2'b00;
    logic       auto_restart = 1'b0, sw_wr = 1'b0, sw_wdata = 1'b0, period_start = 1'b0;
    logic [3:0] pwm_in = 4'b0000;
    logic [3:0] pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm_trip_guard u0 (
        .clk(clk), .rst(rst), .cmp1_trip(cmp1_trip), .cmp2_trip(cmp2_trip),
        .fault_n(fault_n), .src_sel(src_sel), .safe_ac(safe_ac), .safe_bd(safe_bd),
        .auto_restart(auto_restart), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .period_start(period_start), .pwm_in(pwm_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] model(input bit shut, input logic [1:0] ac,
                                         input logic [1:0] bd, input logic [3:0] pwm);
        logic [3:0] o, e;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] c;
            c = (i % 2 == 0) ? ac : bd;
            if (!shut)     begin o[i] = pwm[i]; e[i] = 1'b1; end
            else if (c[1]) begin o[i] = 1'b0;   e[i] = 1'b0; end
            else           begin o[i] = c[0];   e[i] = 1'b1; end
        end
        return {e, o};
    endfunction

    task automatic chk(input string tag, input bit shut);
        logic [7:0] exp_v, got_v;
        exp_v = model(shut, safe_ac, safe_bd, pwm_in);
        got_v = {pin_oe, pin_out};
        checks++;
        if (got_v !== exp_v) begin
            errors++;
            $display("FAIL %s oe/out got %h expected %h", tag, got_v, exp_v);
        end
    endtask

    task automatic nxt;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) nxt;
        rst = 1'b0;
        pwm_in = 4'b0110;
        nxt; #1;
        chk("R1 reset follows pwm", 1'b0);

        // R2 R3 R4: exhaustive combinational sweep, trips removed before each edge
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 8; s++)
                for (int a = 0; a < 4; a++)
                    for (int b = 0; b < 4; b++) begin
                        nxt;
                        src_sel   = m[2:0];
                        cmp1_trip = s[0];
                        cmp2_trip = s[1];
                        fault_n   = ~s[2];
                        safe_ac   = a[1:0];
                        safe_bd   = b[1:0];
                        pwm_in    = 4'(m * 3 + s + a * 5 + b);
                        #1;
                        chk("R2 R3 R4 sweep", (m & s) != 0);
                        #1;
                        cmp1_trip = 1'b0; cmp2_trip = 1'b0; fault_n = 1'b1;
                    end

        safe_ac = 2'b01; safe_bd = 2'b00; pwm_in = 4'b1010;

        // R5: auto restart waits for a period strobe
        auto_restart = 1'b1; src_sel = 3'b001;
        nxt; cmp1_trip = 1'b1; #1; chk("R3 immediate trip", 1'b1);
        nxt; cmp1_trip = 1'b0; #1; chk("R5 held after trip", 1'b1);
        nxt; period_start = 1'b1; #1; chk("R5 before strobe edge", 1'b1);
        nxt; period_start = 1'b0; #1; chk("R5 resumed after strobe", 1'b0);

        // R8: auto clear and strobe on the same edge
        src_sel = 3'b100; safe_bd = 2'b10;
        nxt; fault_n = 1'b0; #1; chk("R4 fault pin trip", 1'b1);
        nxt; fault_n = 1'b1; period_start = 1'b1; #1; chk("R8 trip gone, flag set", 1'b1);
        nxt; period_start = 1'b0; #1; chk("R8 flag set at strobe", 1'b1);
        nxt; nxt; #1; chk("R8 whole period safe", 1'b1);
        nxt; period_start = 1'b1;
        nxt; period_start = 1'b0; #1; chk("R8 resumed next strobe", 1'b0);

        // R6 R7: manual restart with write lockout
        auto_restart = 1'b0; src_sel = 3'b010; safe_ac = 2'b11; safe_bd = 2'b01;
        nxt; cmp2_trip = 1'b1; sw_wr = 1'b1; sw_wdata = 1'b0;
        nxt; sw_wr = 1'b0; #1; chk("R7 write during trip", 1'b1);
        nxt; cmp2_trip = 1'b0; period_start = 1'b1;
        nxt; period_start = 1'b0; #1; chk("R7 flag kept after locked write", 1'b1);
        nxt; period_start = 1'b1;
        nxt; period_start = 1'b0; #1; chk("R6 no auto clear", 1'b1);
        nxt; sw_wr = 1'b1; sw_wdata = 1'b0;
        nxt; sw_wr = 1'b0; #1; chk("R6 cleared, awaiting strobe", 1'b1);
        nxt; period_start = 1'b1;
        nxt; period_start = 1'b0; #1; chk("R6 resumed after clear", 1'b0);

        // R9: software forced shutdown
        nxt; sw_wr = 1'b1; sw_wdata = 1'b1; #1; chk("R9 before edge", 1'b0);
        nxt; sw_wr = 1'b0; #1; chk("R9 forced safe", 1'b1);
        nxt; sw_wr = 1'b1; sw_wdata = 1'b0;
        nxt; sw_wr = 1'b0; period_start = 1'b1;
        nxt; period_start = 1'b0; #1; chk("R9 released", 1'b0);

        // R10: trip present at a strobe edge
        auto_restart = 1'b1; src_sel = 3'b001;
        nxt; cmp1_trip = 1'b1; period_start = 1'b1;
        nxt; cmp1_trip = 1'b0; period_start = 1'b0; #1; chk("R10 trip beats strobe", 1'b1);
        nxt; period_start = 1'b1;
        nxt; period_start = 1'b0; #1; chk("R10 recovered", 1'b0);

        // R2: sources outside the mask ignored across edges
        src_sel = 3'b110;
        nxt; cmp1_trip = 1'b1;
        nxt; #1; chk("R2 masked source no trip", 1'b0);
        cmp1_trip = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule